// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This unit adds or subtracts two 64-bit operands as a set of independent lanes. A runtime select splits the word into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Carries and borrows stop at every lane edge, so each lane behaves like a separate adder.

Each operation picks one of three overflow behaviours. Wraparound keeps the low bits of the lane. Signed saturation clamps a lane to its most positive or most negative value. Unsigned saturation clamps a lane to all-ones on overflow and to zero on underflow. Each lane clamps on its own.

The operands are presented with a valid strobe. The lane result is captured in an output register one clock later, together with an output valid flag.

Top module: `simd_addsub`

## Requirements
- R1: With lane_sel = 2'b00 the word is eight 8-bit lanes (lane k at bits 8k+7..8k), each computed independently.
- R2: With lane_sel = 2'b01 the word is four 16-bit lanes (lane k at bits 16k+15..16k), each computed independently.
- R3: With lane_sel = 2'b10 the word is two 32-bit lanes (low lane at bits 31..0, high lane at bits 63..32).
- R4: With lane_sel = 2'b11 the word is a single 64-bit lane.
- R5: With sat_mode = 2'b00 (or 2'b11) each lane gives a + b (op_sub = 0) or a - b (op_sub = 1) modulo 2^lane width. No carry or borrow crosses a lane edge.
- R6: With sat_mode = 2'b01 each lane is treated as two's complement. A result above the lane maximum gives 0111..1, and a result below the lane minimum gives 1000..0.
- R7: With sat_mode = 2'b10 each lane is treated as unsigned. An add that overflows gives all-ones, and a subtract that underflows gives zero.
- R8: When in_valid is high at a clock edge, result and out_valid = 1 appear after that edge. When in_valid is low at an edge, out_valid is 0 after it and result keeps its previous value.
- R9: While rst_n is low, out_valid and result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| op_sub | input | 1 | 0 = add, 1 = subtract (a - b) |
| sat_mode | input | 2 | 00/11 wrap, 01 signed saturate, 10 unsigned saturate |
| lane_sel | input | 2 | 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = 64-bit lanes |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered lane-wise result |

## Verification
The bench builds the unit with its default slice width of 8 bits, which gives the full 64-bit word. At that width all four lane sizes can be selected. Every lane size is driven with every overflow mode and both operations. The inputs include directed edge patterns: 0x7F/0x80 boundaries, all-ones plus one, zero minus one, and carry chains that reach a lane edge. Pseudo-random operands are added on top. A lane-by-lane arithmetic model supplies the expected word for each input.

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int SLICE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [8*SLICE_W-1:0]   op_a,
  input  logic [8*SLICE_W-1:0]   op_b,
  input  logic                   op_sub,
  input  logic [1:0]             sat_mode,
  input  logic [1:0]             lane_sel,
  output logic                   out_valid,
  output logic [8*SLICE_W-1:0]   result
);
  localparam int NSLICE = 8;
  localparam int DATA_W = NSLICE * SLICE_W;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] raw_sum;
  logic [DATA_W-1:0] lane_res;
  logic [NSLICE-1:0] c_msb;
  logic [NSLICE-1:0] c_out;

  assign b_eff = op_sub ? ~op_b : op_b;

  always_comb begin
    logic              carry;
    logic              cin;
    logic [SLICE_W-1:0] lo;
    logic [1:0]        hi;
    int                mask;
    carry   = 1'b0;
    raw_sum = '0;
    c_msb   = '0;
    c_out   = '0;
    mask    = (1 << lane_sel) - 1;
    for (int i = 0; i < NSLICE; i++) begin
      cin = ((i & mask) == 0) ? op_sub : carry;
      lo  = {1'b0, op_a[i*SLICE_W +: SLICE_W-1]} + {1'b0, b_eff[i*SLICE_W +: SLICE_W-1]}
            + SLICE_W'(cin);
      hi  = {1'b0, op_a[i*SLICE_W+SLICE_W-1]} + {1'b0, b_eff[i*SLICE_W+SLICE_W-1]}
            + {1'b0, lo[SLICE_W-1]};
      raw_sum[i*SLICE_W +: SLICE_W] = {hi[0], lo[SLICE_W-2:0]};
      c_msb[i] = lo[SLICE_W-1];
      c_out[i] = hi[1];
      carry    = hi[1];
    end
  end

  always_comb begin
    int   e;
    int   mask;
    logic top;
    logic s_ovf;
    logic u_ovf;
    logic a_neg;
    mask     = (1 << lane_sel) - 1;
    lane_res = raw_sum;
    for (int i = 0; i < NSLICE; i++) begin
      e     = i | mask;
      top   = (i == e);
      s_ovf = c_msb[e] ^ c_out[e];
      u_ovf = c_out[e] ^ op_sub;
      a_neg = op_a[e*SLICE_W+SLICE_W-1];
      if (sat_mode == 2'b01 && s_ovf) begin
        if (a_neg)
          lane_res[i*SLICE_W +: SLICE_W] = top ? {1'b1, {(SLICE_W-1){1'b0}}} : '0;
        else
          lane_res[i*SLICE_W +: SLICE_W] = top ? {1'b0, {(SLICE_W-1){1'b1}}} : '1;
      end else if (sat_mode == 2'b10 && u_ovf) begin
        lane_res[i*SLICE_W +: SLICE_W] = op_sub ? '0 : '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= lane_res;
    end
  end

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result));
  a_r4_quad_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && lane_sel == 2'b11 && sat_mode == 2'b00
      |=> result == ($past(op_sub) ? $past(op_a) - $past(op_b) : $past(op_a) + $past(op_b)));
  a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_b == '0 |=> result == $past(op_a));
  a_r7_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && sat_mode == 2'b10 && !op_sub && op_a == '1 |=> result == '1);
endmodule

// File: tb/simd_addsub_tb.sv
module simd_addsub_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        op_sub = 1'b0;
  logic [1:0]  sat_mode = 2'b00;
  logic [1:0]  lane_sel = 2'b00;
  logic        out_valid;
  logic [63:0] result;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_exp = '0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #10 clk = ~clk;

  simd_addsub u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .sat_mode(sat_mode), .lane_sel(lane_sel),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic sub, input logic [1:0] mode,
                                        input logic [1:0] sel);
    int w = 8 << sel;
    logic [63:0] r = '0;
    logic signed [65:0] m = (66'sd1 <<< w) - 66'sd1;
    for (int k = 0; k < 64 / w; k++) begin
      logic signed [65:0] ua, ub, s, sa, sb, sr, mx, mn, lane;
      ua = ($signed({2'b00, a}) >>> (k*w)) & m;
      ub = ($signed({2'b00, b}) >>> (k*w)) & m;
      s  = sub ? ua - ub : ua + ub;
      lane = s & m;
      if (mode == 2'b01) begin
        sa = ua[w-1] ? ua - (66'sd1 <<< w) : ua;
        sb = ub[w-1] ? ub - (66'sd1 <<< w) : ub;
        sr = sub ? sa - sb : sa + sb;
        mx = (66'sd1 <<< (w-1)) - 66'sd1;
        mn = -(66'sd1 <<< (w-1));
        if (sr > mx) lane = mx & m;
        else if (sr < mn) lane = mn & m;
      end else if (mode == 2'b10) begin
        if (!sub && s[w]) lane = m;
        if (sub && ua < ub) lane = '0;
      end
      r = r | (lane[63:0] << (k*w));
    end
    return r;
  endfunction

  function automatic logic [63:0] next_rand(input logic [63:0] x);
    logic [63:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [63:0] a, input logic [63:0] b,
                      input logic sub, input logic [1:0] mode, input logic [1:0] sel);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = sub; sat_mode = mode; lane_sel = sel; in_valid = 1'b1;
    exp_q.push_back(model(a, b, sub, mode, sel));
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        last_exp = exp_q.pop_front();
        check(tag_q.pop_front(), result, last_exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [63:0] pa[6];
    logic [63:0] pb[6];
    string tag;
    pa[0] = 64'h7F7F_7F7F_7F7F_7F7F; pb[0] = 64'h0101_0101_0101_0101;
    pa[1] = 64'h8080_8080_8080_8080; pb[1] = 64'h0101_0101_0101_0101;
    pa[2] = 64'hFFFF_FFFF_FFFF_FFFF; pb[2] = 64'h0000_0000_0000_0001;
    pa[3] = 64'h0000_0000_0000_0000; pb[3] = 64'h0000_0001_0001_0101;
    pa[4] = 64'h00FF_00FF_FFFF_00FF; pb[4] = 64'h0001_0001_0001_0001;
    pa[5] = 64'h7FFF_FFFF_8000_0000; pb[5] = 64'h8000_0000_7FFF_FFFF;

    #35;
    check("R9 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R9 result in reset", result, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int sel = 0; sel < 4; sel++) begin
      for (int mode = 0; mode < 3; mode++) begin
        for (int sub = 0; sub < 2; sub++) begin
          if (mode == 1) tag = "R6";
          else if (mode == 2) tag = "R7";
          else tag = (sel == 0) ? "R1" : (sel == 1) ? "R2" : (sel == 2) ? "R3" : "R4";
          for (int p = 0; p < 6; p++)
            send(tag, pa[p], pb[p], sub[0], mode[1:0], sel[1:0]);
          for (int r = 0; r < 8; r++) begin
            logic [63:0] ra;
            rng = next_rand(rng); ra = rng;
            rng = next_rand(rng);
            send(tag, ra, rng, sub[0], mode[1:0], sel[1:0]);
          end
        end
      end
    end

    send("R5 carry stops at byte edge", 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1'b0, 2'b00, 2'b00);
    send("R5 carry crosses in 16-bit", 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1'b0, 2'b00, 2'b01);
    send("R5 borrow stops at 32-bit edge", 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 1'b1, 2'b11, 2'b10);
    send("R5 borrow crosses in 64-bit", 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 1'b1, 2'b00, 2'b11);
    send("R8 last before idle", 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0, 2'b00, 2'b00);

    @(negedge clk);
    in_valid = 1'b0;
    op_a = '1; op_b = '1; op_sub = 1'b1; sat_mode = 2'b01; lane_sel = 2'b11;
    repeat (3) @(negedge clk);
    check("R8 out_valid low when idle", {63'd0, out_valid}, 64'd0);
    check("R8 result held when idle", result, last_exp);
    check("R8 all results delivered", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule